// File: doc/BRIEF.md
# Ring Oscillator Frequency Meter

This block measures how fast an on-chip oscillator runs by timing it against the reference clock. Software programs a target number of measured-clock cycles and sets a start bit. The meter then counts reference-clock cycles until the measured clock has completed that many cycles. The count is latched into a result register, and a done flag is raised. The ratio of the target to the result gives the oscillator frequency in units of the reference. That arithmetic is left to software.

The measured clock reaches the counter only while a separate free-run gate bit is set. That gate and the start bit are carried into the measured domain through flop synchronisers. The measured-cycle counter runs in its own domain. Its completion comes back to the reference domain as a toggle that passes through a two-flop synchroniser. A typical target is 1024 cycles. A result of zero means that no measurement completed.

Top module: `rofm_top`

## Requirements
- R1: After reset, the control, result and status registers all read zero.
- R2: The control word is at offset 0x00. The start bit is bit 24 and the target count is in the low TGT_W bits. Both read back as written, and all other bits read zero.
- R3: The status word is at offset 0x10. Bit 8 is the free-run gate, which can be read and written. Bit 0 is the done flag, which is read-only, so a write to bit 0 has no effect. All other bits read zero.
- R4: With start and gate both set, the result at offset 0x0C is the number of reference cycles taken by T measured cycles plus a bounded synchroniser delay. For measured period Pm and reference period Pr, the result lies in floor(T*Pm/Pr) .. floor((T+5)*Pm/Pr)+6.
- R5: Once the done flag rises, it stays high and the result does not change for as long as start stays set.
- R6: Clearing start aborts any measurement, clears the done flag, resets the counters and zeroes the result. A later measurement then works normally.
- R7: While the gate is clear, no measurement completes: the done flag stays 0 and the result stays 0.
- R8: The reference counter saturates at all ones and does not wrap. A measurement that completes after saturation reports 2^RES_W-1.
- R9: A target of zero behaves as a target of one.
- R10: The result is never zero while the done flag is set.
- R11: Reads of unmapped offsets return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_clk | input | 1 | Oscillator clock being measured |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte offset within the meter bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |

## Verification
The bench builds the meter with TGT_W=6 and RES_W=10. With a 10-bit result, the saturation point of 1023 reference cycles is reached within about a thousand cycles of an ungated run. With a 6-bit target, every measurement stays well below that point. The bench sweeps targets from 0 to 63 across three measured clock periods that are not multiples of the reference period. This exercises the completion window, the zero-target case and the abort-and-restart path on each ratio.

// File: rtl/rofm_pkg.sv
`timescale 1ns/1ps
package rofm_pkg;
    localparam logic [31:0] OFS_CTRL = 32'h00;
    localparam logic [31:0] OFS_RES  = 32'h0C;
    localparam logic [31:0] OFS_STAT = 32'h10;

    localparam int BIT_START = 24;
    localparam int BIT_GATE  = 8;
    localparam int BIT_DONE  = 0;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_RES,
        SEL_STAT
    } reg_sel_e;

    typedef struct packed {
        logic start;
        logic gate;
    } ctl_bits_t;

    function automatic reg_sel_e decode_ofs(input logic [31:0] ofs);
        reg_sel_e s;
        case (ofs)
            OFS_CTRL: s = SEL_CTRL;
            OFS_RES:  s = SEL_RES;
            OFS_STAT: s = SEL_STAT;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/rofm_regs.sv
`timescale 1ns/1ps
module rofm_regs
    import rofm_pkg::*;
#(
    parameter int TGT_W  = 24,
    parameter int RES_W  = 24,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              done_i,
    input  logic [RES_W-1:0]  result_i,
    output logic [31:0]       rdata,
    output logic              start_o,
    output logic              arm_o,
    output logic [TGT_W-1:0]  target_o
);
    localparam int PAD = 32 - ADDR_W;

    ctl_bits_t  ctl_q;
    logic [TGT_W-1:0] target_q;
    reg_sel_e   sel;
    logic       unused_wbits;

    assign sel          = decode_ofs({{PAD{1'b0}}, addr});
    assign unused_wbits = ^wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q    <= '0;
            target_q <= '0;
            arm_o    <= 1'b0;
        end else begin
            if (wr && sel == SEL_CTRL) begin
                ctl_q.start <= wdata[BIT_START];
                target_q    <= wdata[TGT_W-1:0];
            end
            if (wr && sel == SEL_STAT) begin
                ctl_q.gate <= wdata[BIT_GATE];
            end
            // Only one of the two bits can change per cycle; registering the
            // AND gives the far domain a single glitch-free source.
            arm_o <= ctl_q.start & ctl_q.gate;
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_CTRL: begin
                rdata[TGT_W-1:0] = target_q;
                rdata[BIT_START] = ctl_q.start;
            end
            SEL_RES:  rdata[RES_W-1:0] = result_i;
            SEL_STAT: begin
                rdata[BIT_GATE] = ctl_q.gate;
                rdata[BIT_DONE] = done_i;
            end
            default:  rdata = '0;
        endcase
    end

    assign start_o  = ctl_q.start;
    assign target_o = target_q;

    // The arm line never rises while the start bit is clear.
    assert_arm_needs_start_R7: assert property (@(posedge clk) disable iff (rst)
        !ctl_q.start |=> !arm_o);
endmodule

// File: rtl/rofm_fast_side.sv
`timescale 1ns/1ps
module rofm_fast_side #(
    parameter int TGT_W = 24
) (
    input  logic             mclk,
    input  logic             rst,
    input  logic             arm_i,
    input  logic [TGT_W-1:0] target_i,
    output logic             done_tgl
);
    localparam int CW = TGT_W + 1;

    logic [1:0]    rst_sync;
    logic [1:0]    arm_sync;
    logic          rst_m;
    logic          armed;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;
    logic [CW-1:0] tgt_eff;
    logic          fin;

    assign rst_m   = rst_sync[1];
    assign armed   = arm_sync[1];
    assign cnt_nxt = cnt + 1'b1;
    assign tgt_eff = (target_i == '0) ? CW'(1) : {1'b0, target_i};

    always_ff @(posedge mclk) begin
        rst_sync <= {rst_sync[0], rst};
    end

    always_ff @(posedge mclk) begin
        if (rst_m) begin
            arm_sync <= '0;
            cnt      <= '0;
            fin      <= 1'b0;
            done_tgl <= 1'b0;
        end else begin
            arm_sync <= {arm_sync[0], arm_i};
            if (!armed) begin
                cnt <= '0;
                fin <= 1'b0;
            end else if (!fin) begin
                cnt <= cnt_nxt;
                if (cnt_nxt >= tgt_eff) begin
                    fin      <= 1'b1;
                    done_tgl <= ~done_tgl;
                end
            end
        end
    end

    // One completion event per armed interval.
    assert_one_toggle_R4: assert property (@(posedge mclk) disable iff (rst_m)
        (fin && armed) |=> $stable(done_tgl));
endmodule

// File: rtl/rofm_ref_side.sv
`timescale 1ns/1ps
module rofm_ref_side #(
    parameter int RES_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             tgl_i,
    output logic             done_o,
    output logic [RES_W-1:0] result_o
);
    logic [2:0]       tsync;
    logic             done_p;
    logic [RES_W-1:0] cnt;
    logic [RES_W-1:0] cnt_inc;
    logic             at_max;

    assign done_p  = tsync[1] ^ tsync[2];
    assign at_max  = &cnt;
    assign cnt_inc = at_max ? cnt : cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) tsync <= '0;
        else     tsync <= {tsync[1:0], tgl_i};
    end

    always_ff @(posedge clk) begin
        if (rst || !start_i) begin
            cnt      <= '0;
            done_o   <= 1'b0;
            result_o <= '0;
        end else if (!done_o) begin
            if (done_p) begin
                done_o   <= 1'b1;
                result_o <= cnt_inc;
            end else begin
                cnt <= cnt_inc;
            end
        end
    end

    assert_done_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (done_o && start_i) |=> done_o);
    assert_result_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (done_o && start_i) |=> $stable(result_o));
    assert_abort_clears_R6: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> (!done_o && result_o == '0));
    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (start_i && !done_o && at_max) |=> (done_o || at_max));
    assert_nonzero_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (result_o != '0));
endmodule

// File: rtl/rofm_top.sv
`timescale 1ns/1ps
module rofm_top #(
    parameter int TGT_W  = 24,
    parameter int RES_W  = 24,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              meas_clk,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    logic             start;
    logic             arm;
    logic [TGT_W-1:0] target;
    logic             tgl;
    logic             done;
    logic [RES_W-1:0] result;

    rofm_regs #(.TGT_W(TGT_W), .RES_W(RES_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .done_i(done), .result_i(result), .rdata(bus_rdata),
        .start_o(start), .arm_o(arm), .target_o(target)
    );

    rofm_fast_side #(.TGT_W(TGT_W)) u_fast (
        .mclk(meas_clk), .rst(rst), .arm_i(arm), .target_i(target),
        .done_tgl(tgl)
    );

    rofm_ref_side #(.RES_W(RES_W)) u_ref (
        .clk(clk), .rst(rst), .start_i(start), .tgl_i(tgl),
        .done_o(done), .result_o(result)
    );
endmodule

// File: tb/sim_rofm_top.sv
`timescale 1ns/1ps
module sim_rofm_top;
    localparam int TGT_W = 6;
    localparam int RES_W = 10;
    localparam int ADDR_W = 8;
    localparam real PR = 20.0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mclk = 1'b0;
    logic bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    real mhalf = 3.1;
    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    rofm_top #(.TGT_W(TGT_W), .RES_W(RES_W), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst(rst), .meas_clk(mclk), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #10 clk = ~clk;
    initial begin
        #1.3;
        forever #(mhalf) mclk = ~mclk;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_done(output bit ok);
        logic [31:0] s;
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            rd(8'h10, s);
            if (s[0]) begin ok = 1'b1; break; end
        end
    endtask

    task automatic measure(input int t, input real pm);
        logic [31:0] v, v2;
        bit ok;
        int te, lo, hi;
        te = (t == 0) ? 1 : t;
        lo = int'($floor(te * pm / PR));
        hi = int'($floor((te + 5) * pm / PR)) + 6;
        mhalf = pm / 2.0;
        wr(8'h10, 32'h100);
        wr(8'h00, 32'h0100_0000 | t);
        wait_done(ok);
        chk(ok, "R4 done flag rises", ok, 1);
        rd(8'h0C, v);
        chk(v >= lo && v <= hi, (t == 0) ? "R9 zero target as one" : "R4 result in window", v, lo);
        chk(v != 0, "R10 nonzero result", v, 1);
        repeat (5) @(negedge clk);
        rd(8'h0C, v2);
        chk(v2 == v, "R5 result stable", v2, v);
        rd(8'h10, v2);
        chk(v2[0] == 1'b1, "R5 done holds", v2[0], 1);
        wr(8'h00, 32'h0);
        repeat (2) @(negedge clk);
        rd(8'h10, v2);
        chk(v2[0] == 1'b0, "R6 abort clears done", v2[0], 0);
        rd(8'h0C, v2);
        chk(v2 == 0, "R6 abort zeroes result", v2, 0);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        #(20.0 * 150000);
        nfail++;
        nchk++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        real pms [3] = '{6.2, 14.6, 46.2};
        int tgs [8] = '{0, 1, 2, 3, 7, 16, 40, 63};
        bit ok;
        repeat (6) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        rd(8'h00, v); chk(v == 0, "R1 ctrl reset", v, 0);
        rd(8'h0C, v); chk(v == 0, "R1 result reset", v, 0);
        rd(8'h10, v); chk(v == 0, "R1 status reset", v, 0);

        // R2 layout: start bit 24, target low TGT_W bits
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); chk(v == 32'h0100_003F, "R2 ctrl readback", v, 32'h0100_003F);
        wr(8'h00, 32'h0);
        rd(8'h00, v); chk(v == 0, "R2 ctrl cleared", v, 0);

        // R3: bit 8 gate writable, bit 0 done read-only
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, v); chk(v == 32'h100, "R3 status readback", v, 32'h100);
        wr(8'h10, 32'h1);
        rd(8'h10, v); chk(v == 0, "R3 done not writable", v, 0);

        // R11: unmapped offsets
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, v); chk(v == 0, "R11 unmapped reads zero", v, 0);
        rd(8'h00, v); chk(v == 0, "R11 ctrl untouched", v, 0);
        rd(8'h10, v); chk(v == 0, "R11 status untouched", v, 0);

        foreach (pms[p]) begin
            foreach (tgs[k]) measure(tgs[k], pms[p]);
        end

        // R7 and R8: gate off, reference counter runs into saturation
        mhalf = 7.3;
        wr(8'h10, 32'h0);
        wr(8'h00, 32'h0100_0004);
        repeat (1100) @(negedge clk);
        rd(8'h10, v); chk(v[0] == 1'b0, "R7 no completion while gated", v[0], 0);
        rd(8'h0C, v); chk(v == 0, "R7 result zero while gated", v, 0);
        wr(8'h10, 32'h100);
        wait_done(ok);
        chk(ok, "R8 completes after saturation", ok, 1);
        rd(8'h0C, v); chk(v == 1023, "R8 saturated result", v, 1023);
        wr(8'h00, 32'h0);
        repeat (20) @(negedge clk);

        // R6: a fresh measurement after an abort
        measure(10, 14.6);

        finished = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule